// File: doc/BRIEF.md
# Receive Queue Interrupt and Idle Timeout Controller

This block sits next to the 16-entry receive queue of a 16550-class UART. It watches the queue occupancy and raises a data-available request once the occupancy reaches a level chosen by a 2-bit code. It also keeps a data-ready status flag. A character-idle timer raises a timeout request when characters are left unread in the queue and both the serial side and the CPU have been quiet for four character times.

The timer counts only on the receiver's 16x oversampling enable, so its length follows the baud rate. The length of one character comes from the word length, the parity enable and the stop-bit setting. Both requests are gated by the queue-mode enable and the receive-interrupt enable. A queue flush clears all state. The serial shifter, the queue storage and the register decode are outside this block. The occupancy count, the push pulse and the read strobe arrive from those neighbours.

Top module: `rxq_alert_unit`

## Requirements
- R1: `data_avail_req` is high one cycle after `fifo_count` is at or above the selected level. The levels for `trig_code` 00, 01, 10 and 11 are 1, 4, 8 and 14 entries.
- R2: `data_avail_req` falls one cycle after `fifo_count` drops below the selected level.
- R3: `data_ready` is set one cycle after `push_pulse`. It clears one cycle after `fifo_count` is 0 with no push. The enables do not affect it.
- R4: `idle_tmo_req` never asserts while `fifo_count` is 0.
- R5: With data in the queue and no push or read, `idle_tmo_req` rises after exactly 64×B cycles that have `baud_tick` high. B = 1 start + (5 + `word_len`) data + `parity_en` + (1 + `two_stop`) stop. Cycles without `baud_tick` do not advance the timer.
- R6: The parity bit and the second stop bit each lengthen the timeout by 64 ticks. For example, 8 data bits with parity and two stop bits give 768 ticks.
- R7: While no timeout is pending, a `push_pulse` or a `pop_strobe` restarts the full count.
- R8: A pending timeout is cleared one cycle after `pop_strobe`, which also restarts the timer. A `push_pulse` leaves a pending timeout in place.
- R9: Both requests stay low, and the timer is held at zero, unless `fifo_en` and `rx_irq_en` are both 1.
- R10: One cycle after `fifo_flush`, all three outputs are 0 and the timer restarts from zero. After reset, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fifo_flush | input | 1 | Receive queue clear pulse |
| fifo_en | input | 1 | Queue mode enable |
| rx_irq_en | input | 1 | Receive interrupt enable |
| trig_code | input | 2 | Level select: 00=1, 01=4, 10=8, 11=14 |
| word_len | input | 2 | Data bits minus 5 |
| parity_en | input | 1 | Parity bit present |
| two_stop | input | 1 | Second stop bit present |
| baud_tick | input | 1 | 16x oversampling enable |
| push_pulse | input | 1 | A character entered the queue |
| pop_strobe | input | 1 | CPU read of the queue |
| fifo_count | input | 5 | Queue occupancy, 0 to 16 |
| data_avail_req | output | 1 | Level-reached request |
| idle_tmo_req | output | 1 | Character timeout request |
| data_ready | output | 1 | Data-ready status |

## Verification
The hardest conditions to reach are the exact expiry edge of the idle timer and the pending state when a push arrives during it. Expiry takes hundreds of baud enables, and the count must stay nonzero with no push or read the whole time. The stimulus holds the occupancy constant from outside the block and starts each run with one push. For the longest frame it gives baud enables only on alternate cycles. It counts the enables and samples the output one enable before and exactly at the computed limit. With the timeout pending, it then adds a push and a read to separate the rule that keeps the timeout from the rule that clears it.

// File: rtl/rxq_irq_pkg.sv
package rxq_irq_pkg;

    typedef enum logic [1:0] {
        TRIG_ONE      = 2'b00,
        TRIG_QUARTER  = 2'b01,
        TRIG_HALF     = 2'b10,
        TRIG_NEARFULL = 2'b11
    } trig_sel_e;

    // Occupancy level that raises the data-available request
    function automatic int unsigned level_of(trig_sel_e sel, int unsigned depth);
        case (sel)
            TRIG_ONE:      return 1;
            TRIG_QUARTER:  return depth / 4;
            TRIG_HALF:     return depth / 2;
            default:       return depth - 2;
        endcase
    endfunction

    // Bits in one serial frame: start, data, parity, stop(s)
    function automatic int unsigned frame_bits(logic [1:0] wl, logic par, logic two);
        return 32'd7 + 32'(wl) + 32'(par) + 32'(two);
    endfunction

endpackage

// File: rtl/rxq_level_watch.sv
module rxq_level_watch
    import rxq_irq_pkg::*;
#(
    parameter int unsigned DEPTH = 16,
    parameter int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             active,
    input  logic [1:0]       trig_code,
    input  logic             push,
    input  logic [CNT_W-1:0] fifo_count,
    output logic             avail,
    output logic             dready
);

    typedef struct packed {
        logic avail;
        logic dready;
    } lw_state_t;

    lw_state_t  st_d, st_q;
    logic [CNT_W-1:0] level;

    always_comb begin
        level = CNT_W'(level_of(trig_sel_e'(trig_code), DEPTH));
        st_d  = st_q;
        st_d.avail = !flush && active && (fifo_count >= level);
        if (flush) begin
            st_d.dready = 1'b0;
        end else if (push) begin
            st_d.dready = 1'b1;
        end else if (fifo_count == '0) begin
            st_d.dready = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign avail  = st_q.avail;
    assign dready = st_q.dready;

    AST_AVAIL_NEEDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        avail |-> ($past(fifo_count) != '0)); // R1
    AST_AVAIL_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> !avail); // R9
    AST_DREADY_ON_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !flush) |=> dready); // R3
    AST_FLUSH_LEVEL_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (!avail && !dready)); // R10

endmodule

// File: rtl/rxq_idle_timer.sv
module rxq_idle_timer
    import rxq_irq_pkg::*;
#(
    parameter int unsigned CNT_W      = 5,
    parameter int unsigned OVERSAMPLE = 16,
    parameter int unsigned CHAR_SPAN  = 4,
    parameter int unsigned MAX_BITS   = 12,
    parameter int unsigned TMR_W      = $clog2(CHAR_SPAN * OVERSAMPLE * MAX_BITS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             active,
    input  logic [CNT_W-1:0] fifo_count,
    input  logic             push,
    input  logic             pop,
    input  logic             baud_tick,
    input  logic [1:0]       word_len,
    input  logic             parity_en,
    input  logic             two_stop,
    output logic             tmo_pending
);

    typedef struct packed {
        logic [TMR_W-1:0] cnt;
        logic             pend;
    } tmr_state_t;

    tmr_state_t       st_d, st_q;
    logic [TMR_W-1:0] limit;

    always_comb begin
        limit = TMR_W'(CHAR_SPAN * OVERSAMPLE * frame_bits(word_len, parity_en, two_stop));
        st_d  = st_q;
        if (flush || !active || (fifo_count == '0)) begin
            st_d = '0;
        end else if (pop) begin
            st_d = '0;
        end else if (st_q.pend) begin
            st_d = st_q;
        end else if (push) begin
            st_d.cnt = '0;
        end else if (baud_tick) begin
            if (st_q.cnt >= limit - 1'b1) begin
                st_d.cnt  = '0;
                st_d.pend = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tmo_pending = st_q.pend;

    AST_TMO_NEEDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_count == '0) |=> !tmo_pending); // R4
    AST_TMO_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tmo_pending) |-> $past(baud_tick)); // R5
    AST_POP_CLEARS_TMO: assert property (@(posedge clk) disable iff (!rst_n)
        pop |=> !tmo_pending); // R8
    AST_TMO_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> !tmo_pending); // R9
    AST_FLUSH_TMO_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !tmo_pending); // R10

endmodule

// File: rtl/rxq_alert_unit.sv
module rxq_alert_unit #(
    parameter int unsigned DEPTH      = 16,
    parameter int unsigned OVERSAMPLE = 16,
    parameter int unsigned CHAR_SPAN  = 4,
    parameter int unsigned CNT_W      = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fifo_flush,
    input  logic             fifo_en,
    input  logic             rx_irq_en,
    input  logic [1:0]       trig_code,
    input  logic [1:0]       word_len,
    input  logic             parity_en,
    input  logic             two_stop,
    input  logic             baud_tick,
    input  logic             push_pulse,
    input  logic             pop_strobe,
    input  logic [CNT_W-1:0] fifo_count,
    output logic             data_avail_req,
    output logic             idle_tmo_req,
    output logic             data_ready
);

    localparam int unsigned MAX_BITS = 12;

    logic active;
    assign active = fifo_en && rx_irq_en;

    rxq_level_watch #(
        .DEPTH (DEPTH),
        .CNT_W (CNT_W)
    ) u_level (
        .clk        (clk),
        .rst_n      (rst_n),
        .flush      (fifo_flush),
        .active     (active),
        .trig_code  (trig_code),
        .push       (push_pulse),
        .fifo_count (fifo_count),
        .avail      (data_avail_req),
        .dready     (data_ready)
    );

    rxq_idle_timer #(
        .CNT_W      (CNT_W),
        .OVERSAMPLE (OVERSAMPLE),
        .CHAR_SPAN  (CHAR_SPAN),
        .MAX_BITS   (MAX_BITS)
    ) u_timer (
        .clk         (clk),
        .rst_n       (rst_n),
        .flush       (fifo_flush),
        .active      (active),
        .fifo_count  (fifo_count),
        .push        (push_pulse),
        .pop         (pop_strobe),
        .baud_tick   (baud_tick),
        .word_len    (word_len),
        .parity_en   (parity_en),
        .two_stop    (two_stop),
        .tmo_pending (idle_tmo_req)
    );

    AST_TMO_IMPLIES_DATA_READY: assert property (@(posedge clk) disable iff (!rst_n)
        idle_tmo_req |-> data_ready); // R3

endmodule

// File: tb/test_rxq_alert_unit.sv
`timescale 1ns/1ps
module test_rxq_alert_unit;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       fifo_flush, fifo_en, rx_irq_en;
    logic [1:0] trig_code, word_len;
    logic       parity_en, two_stop, baud_tick, push_pulse, pop_strobe;
    logic [4:0] fifo_count;
    logic       data_avail_req, idle_tmo_req, data_ready;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    rxq_alert_unit i_rxq_alert_unit (
        .clk            (clk),
        .rst_n          (rst_n),
        .fifo_flush     (fifo_flush),
        .fifo_en        (fifo_en),
        .rx_irq_en      (rx_irq_en),
        .trig_code      (trig_code),
        .word_len       (word_len),
        .parity_en      (parity_en),
        .two_stop       (two_stop),
        .baud_tick      (baud_tick),
        .push_pulse     (push_pulse),
        .pop_strobe     (pop_strobe),
        .fifo_count     (fifo_count),
        .data_avail_req (data_avail_req),
        .idle_tmo_req   (idle_tmo_req),
        .data_ready     (data_ready)
    );

    // {trig_code[1:0], fifo_count[4:0], expected data_avail_req}
    localparam int NVEC = 12;
    localparam logic [7:0] VEC [NVEC] = '{
        {2'b00, 5'd0,  1'b0}, {2'b00, 5'd1,  1'b1},
        {2'b01, 5'd3,  1'b0}, {2'b01, 5'd4,  1'b1},
        {2'b01, 5'd16, 1'b1}, {2'b10, 5'd7,  1'b0},
        {2'b10, 5'd8,  1'b1}, {2'b11, 5'd13, 1'b0},
        {2'b11, 5'd14, 1'b1}, {2'b11, 5'd16, 1'b1},
        {2'b10, 5'd2,  1'b0}, {2'b00, 5'd5,  1'b1}
    };

    function automatic int tmo_ticks(int wl, int par, int ts);
        return 64 * (1 + 5 + wl + par + 1 + ts);
    endfunction

    task automatic step();
        @(negedge clk);
    endtask

    task automatic chk(string req, string what, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int lim;
        rst_n = 1'b0; fifo_flush = 0; fifo_en = 0; rx_irq_en = 0;
        trig_code = 0; word_len = 0; parity_en = 0; two_stop = 0;
        baud_tick = 0; push_pulse = 0; pop_strobe = 0; fifo_count = 0;
        repeat (3) step();
        rst_n = 1'b1;
        step();
        chk("R10", "reset avail", data_avail_req, 1'b0);
        chk("R10", "reset tmo", idle_tmo_req, 1'b0);
        chk("R10", "reset dready", data_ready, 1'b0);

        fifo_en = 1; rx_irq_en = 1;
        // R1 level table
        for (int i = 0; i < NVEC; i++) begin
            trig_code  = VEC[i][7:6];
            fifo_count = VEC[i][5:1];
            step();
            chk("R1", $sformatf("vector %0d", i), data_avail_req, VEC[i][0]);
        end

        // R2 drop below level
        trig_code = 2'b11; fifo_count = 14; step();
        chk("R2", "at level 14", data_avail_req, 1'b1);
        fifo_count = 13; step();
        chk("R2", "dropped to 13", data_avail_req, 1'b0);

        // R9 level request gated
        fifo_count = 16; rx_irq_en = 0; step();
        chk("R9", "avail disabled", data_avail_req, 1'b0);
        rx_irq_en = 1; step();
        chk("R9", "avail re-enabled", data_avail_req, 1'b1);

        // R3 data ready
        fifo_count = 0; step();
        chk("R3", "empty dready", data_ready, 1'b0);
        push_pulse = 1; fifo_count = 1; step();
        push_pulse = 0;
        chk("R3", "push sets dready", data_ready, 1'b1);
        fifo_count = 0; step();
        chk("R3", "empty clears dready", data_ready, 1'b0);
        rx_irq_en = 0; push_pulse = 1; fifo_count = 1; step();
        push_pulse = 0;
        chk("R3", "dready ignores enables", data_ready, 1'b1);
        rx_irq_en = 1; fifo_count = 0; step();

        // R5 timer expiry, 5N1, tick every cycle
        trig_code = 2'b11;
        lim = tmo_ticks(0, 0, 0);
        push_pulse = 1; fifo_count = 2; step();
        push_pulse = 0; baud_tick = 1;
        repeat (lim - 1) step();
        chk("R5", "one tick before limit", idle_tmo_req, 1'b0);
        step();
        chk("R5", "at limit", idle_tmo_req, 1'b1);

        // R8 push keeps, pop clears
        push_pulse = 1; fifo_count = 3; step();
        push_pulse = 0;
        chk("R8", "push keeps pending", idle_tmo_req, 1'b1);
        pop_strobe = 1; step();
        pop_strobe = 0; fifo_count = 2;
        chk("R8", "pop clears pending", idle_tmo_req, 1'b0);
        repeat (lim - 2) step();
        chk("R8", "pop restarted timer", idle_tmo_req, 1'b0);

        // R7 push restarts while not pending
        push_pulse = 1; fifo_count = 3; step();
        push_pulse = 0;
        repeat (lim - 1) step();
        chk("R7", "push restart, before limit", idle_tmo_req, 1'b0);
        step();
        chk("R7", "push restart, at limit", idle_tmo_req, 1'b1);
        pop_strobe = 1; step();
        pop_strobe = 0;

        // R4 empty queue never times out
        fifo_count = 0;
        repeat (lim + 10) step();
        chk("R4", "empty no timeout", idle_tmo_req, 1'b0);

        // R9 timer gated
        fifo_count = 1; rx_irq_en = 0;
        repeat (lim + 10) step();
        chk("R9", "timeout disabled", idle_tmo_req, 1'b0);
        rx_irq_en = 1;

        // R6 8 data, parity, 2 stop, tick on alternate cycles
        word_len = 2'b11; parity_en = 1; two_stop = 1;
        lim = tmo_ticks(3, 1, 1);
        baud_tick = 0; push_pulse = 1; step();
        push_pulse = 0;
        for (int k = 1; k <= lim; k++) begin
            baud_tick = 1; step();
            baud_tick = 0; step();
            if (k == lim - 1) chk("R6", "768 ticks minus one", idle_tmo_req, 1'b0);
            if (k == 448) chk("R6", "short-frame limit passed", idle_tmo_req, 1'b0);
        end
        chk("R6", "768 ticks reached", idle_tmo_req, 1'b1);

        // R10 flush
        trig_code = 2'b00; fifo_count = 4; step();
        chk("R10", "avail before flush", data_avail_req, 1'b1);
        fifo_flush = 1; step();
        fifo_flush = 0; fifo_count = 0;
        chk("R10", "flush avail", data_avail_req, 1'b0);
        chk("R10", "flush tmo", idle_tmo_req, 1'b0);
        chk("R10", "flush dready", data_ready, 1'b0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule